// File: doc/BRIEF.md
# Translation Table Walker

This block turns one input virtual address into an output physical address. It reads 64-bit descriptors from a multi-level translation table in memory. A request is accepted together with a snapshot of the configuration: the table base register, the input-size field `tsz`, the granule code, and the bypass and disable flags.

The walker works out its starting level from `tsz` and the granule. It then reads one descriptor per level through a request/response memory port. The walk follows table descriptors until it reaches a page or block descriptor, or until it hits a fault. It returns the translated address, an address mask and a fault code, and pulses `done` for one cycle.

The request side uses valid/ready. `req_ready` is high only while the walker is idle. A request is taken on the first edge where `req_valid` and `req_ready` are both high. The memory request side also uses valid/ready: while `mem_req_ready` is low, the walker holds `mem_req_valid` high and keeps `mem_req_addr` unchanged. The response side has no back-pressure. The walker has exactly one read outstanding at a time, so it always accepts `mem_rsp_valid` when it arrives.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: The granule code maps to a page shift g: code 0 gives g=12, code 1 gives g=14, code 2 gives g=16. The shift at level L is g+(3-L)*(g-3). The starting level is 4-(60-tsz)/(g-3), clamped to 0 when the quotient is 4 or more. The first read address is `cfg_ttb[47:0]` plus 8 times ((VA >> shift(start)) masked to g-3 bits).
- R3: A descriptor with bits [1:0]=11 at levels 0 to 2 is a table. The next table base is descriptor bits [46:g] with bits below g cleared. The walk continues one level deeper.
- R4: A descriptor with bits [1:0]=11 at level 3 is a page. `res_addr` is descriptor bits [46:g] combined with VA bits [g-1:0]. `res_mask` is 2^g-1 and `res_fault` is 0x00. Descriptor bits above 46 and below g do not affect the result.
- R5: A descriptor with bits [1:0]=01 is a legal block in these cases only: level 1 or level 2 with the 4 KiB granule, or level 2 with the 16 KiB or 64 KiB granule. For a legal block, `res_addr` is descriptor bits [46:s] combined with VA bits [s-1:0], where s=shift(L), giving block sizes of 1 GiB, 2 MiB, 32 MiB and 512 MiB. `res_mask` is 2^g-1.
- R6: A descriptor with bit 0 = 0 ends the walk with fault code 0x01. A level-3 descriptor with bits [1:0]=01 also ends the walk with fault code 0x01.
- R7: A block descriptor at any level or granule not listed in R5 ends the walk with fault code 0x01.
- R8: A response with `mem_rsp_err` set ends the walk with fault code 0x01.
- R9: A VA above 2^(64-tsz)-1 faults with code 0x01 and issues no memory read.
- R10: When `cfg_bypass` or `cfg_disable` is set, no read is issued and the fault code is 0x00. In this case `res_addr` is VA[47:0] and `res_mask` is 0.
- R11: Granule code 3, or a `tsz` that gives a quotient of 0 in R2, faults with code 0x01 and issues no memory read.
- R12: At most one read is outstanding at a time. A stalled memory request keeps its address. `done` lasts exactly one cycle per accepted request. `req_ready` stays low from acceptance until the walker returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ttb | input | 64 | Table base register; bits [47:0] are used |
| cfg_tsz | input | 6 | Input-size field; input range is 2^(64-tsz) |
| cfg_gran | input | 2 | Granule code: 0=4 KiB, 1=16 KiB, 2=64 KiB |
| cfg_bypass | input | 1 | Skip translation |
| cfg_disable | input | 1 | Translation disabled; no walk |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Input virtual address |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Descriptor value |
| mem_rsp_err | input | 1 | Read failed |
| done | output | 1 | One-cycle result strobe |
| res_addr | output | ADDR_W | Translated address |
| res_mask | output | ADDR_W | Page-size mask |
| res_fault | output | 8 | 0x00 success, 0x01 walk fault |

## Verification
The bench uses the default `ADDR_W` of 48. With that width, the full table base field and descriptor address bits up to 46 are visible at the ports. This lets the bench reach all three granules, starting levels 0, 1 and 2, and block mappings up to 512 MiB. The memory model refuses two of every three request cycles, so each walk also exercises the hold rule for a stalled read. The expected first-read addresses show directly which starting level and index the walker chose.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {GR_4K = 2'd0, GR_16K = 2'd1, GR_64K = 2'd2, GR_BAD = 2'd3} gran_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} state_e;
  typedef enum logic [1:0] {DK_FAULT, DK_TABLE, DK_LEAF} dkind_e;

  localparam logic [7:0] FLT_NONE = 8'h00;
  localparam logic [7:0] FLT_WALK = 8'h01;
  localparam int         DESC_W   = 64;
  localparam int         VA_W     = 64;
  localparam int         TTB_LSB_W = 48;

  function automatic logic [5:0] page_shift(input logic [1:0] gc);
    return 6'd12 + {3'b000, gc, 1'b0};
  endfunction

  function automatic logic [5:0] lvl_shift(input logic [1:0] gc, input logic [1:0] lvl);
    logic [5:0] g;
    logic [7:0] t;
    g = page_shift(gc);
    t = 8'(2'd3 - lvl) * 8'(g - 6'd3);
    return g + t[5:0];
  endfunction
endpackage

// File: rtl/ptw_cfg_decode.sv
module ptw_cfg_decode
  import ptw_pkg::*;
(
  input  logic [1:0]      gran,
  input  logic [5:0]      tsz,
  input  logic [VA_W-1:0] va,
  output logic [1:0]      start_lvl,
  output logic            cfg_bad,
  output logic            va_over
);
  logic [5:0] g;
  logic [6:0] stride;
  logic [6:0] span;
  logic [6:0] quot;

  always_comb begin
    g      = page_shift(gran);
    stride = 7'(g - 6'd3);
    span   = (tsz > 6'd60) ? 7'd0 : (7'd60 - {1'b0, tsz});
    quot   = span / stride;
    cfg_bad   = (gran == GR_BAD) || (quot == 7'd0);
    start_lvl = (quot >= 7'd4) ? 2'd0 : 2'(3'd4 - quot[2:0]);
    va_over   = (tsz != 6'd0) && ((va >> (7'd64 - {1'b0, tsz})) != '0);
  end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        lvl,
  input  logic [1:0]        gran,
  input  logic [VA_W-1:0]   va,
  output dkind_e            kind,
  output logic [ADDR_W-1:0] next_base,
  output logic [ADDR_W-1:0] leaf_addr,
  output logic [ADDR_W-1:0] page_mask
);
  localparam logic [63:0] OA_FIELD = 64'h0000_7FFF_FFFF_FFFF;

  logic [5:0]  g;
  logic [5:0]  sh;
  logic [63:0] field;
  logic [63:0] gmask;
  logic [63:0] lmask;
  logic        block_ok;

  always_comb begin
    g        = page_shift(gran);
    sh       = lvl_shift(gran, lvl);
    field    = desc & OA_FIELD;
    gmask    = (64'd1 << g) - 64'd1;
    block_ok = (gran == GR_4K) ? (lvl == 2'd1 || lvl == 2'd2) : (lvl == 2'd2);
    lmask    = gmask;
    kind     = DK_FAULT;
    if (desc[0]) begin
      if (lvl == 2'd3) begin
        kind = desc[1] ? DK_LEAF : DK_FAULT;
      end else if (desc[1]) begin
        kind = DK_TABLE;
      end else if (block_ok) begin
        kind  = DK_LEAF;
        lmask = (64'd1 << sh) - 64'd1;
      end
    end
    leaf_addr = ADDR_W'((field & ~lmask) | (va & lmask));
    next_base = ADDR_W'(field & ~gmask);
    page_mask = ADDR_W'(gmask);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       cfg_ttb,
  input  logic [5:0]        cfg_tsz,
  input  logic [1:0]        cfg_gran,
  input  logic              cfg_bypass,
  input  logic              cfg_disable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_va,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              done,
  output logic [ADDR_W-1:0] res_addr,
  output logic [ADDR_W-1:0] res_mask,
  output logic [7:0]        res_fault
);
  state_e            st;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        gran_q;
  logic [1:0]        lvl_q;
  logic [ADDR_W-1:0] base_q;

  logic [1:0]        start_lvl;
  logic              cfg_bad;
  logic              va_over;
  dkind_e            kind;
  logic [ADDR_W-1:0] next_base;
  logic [ADDR_W-1:0] leaf_addr;
  logic [ADDR_W-1:0] page_mask;

  ptw_cfg_decode u_cfg (
    .gran      (cfg_gran),
    .tsz       (cfg_tsz),
    .va        (req_va),
    .start_lvl (start_lvl),
    .cfg_bad   (cfg_bad),
    .va_over   (va_over)
  );

  ptw_desc_decode #(.ADDR_W(ADDR_W)) u_desc (
    .desc      (mem_rsp_data),
    .lvl       (lvl_q),
    .gran      (gran_q),
    .va        (va_q),
    .kind      (kind),
    .next_base (next_base),
    .leaf_addr (leaf_addr),
    .page_mask (page_mask)
  );

  // Descriptor address for the current level
  logic [5:0]  cur_sh;
  logic [5:0]  cur_g;
  logic [63:0] idx;
  always_comb begin
    cur_sh       = lvl_shift(gran_q, lvl_q);
    cur_g        = page_shift(gran_q);
    idx          = (va_q >> cur_sh) & ((64'd1 << (cur_g - 6'd3)) - 64'd1);
    mem_req_addr = base_q + ADDR_W'(idx << 3);
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign done          = (st == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      gran_q    <= '0;
      lvl_q     <= '0;
      base_q    <= '0;
      res_addr  <= '0;
      res_mask  <= '0;
      res_fault <= FLT_NONE;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          gran_q <= cfg_gran;
          st     <= ST_FIN;
          if (cfg_bypass || cfg_disable) begin
            res_addr  <= req_va[ADDR_W-1:0];
            res_mask  <= '0;
            res_fault <= FLT_NONE;
          end else if (cfg_bad || va_over) begin
            res_addr  <= '0;
            res_mask  <= '0;
            res_fault <= FLT_WALK;
          end else begin
            base_q <= ADDR_W'(cfg_ttb[TTB_LSB_W-1:0]);
            lvl_q  <= start_lvl;
            st     <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_err && kind == DK_TABLE) begin
            base_q <= next_base;
            lvl_q  <= lvl_q + 2'd1;
            st     <= ST_ISSUE;
          end else if (!mem_rsp_err && kind == DK_LEAF) begin
            res_addr  <= leaf_addr;
            res_mask  <= page_mask;
            res_fault <= FLT_NONE;
            st        <= ST_FIN;
          end else begin
            res_addr  <= '0;
            res_mask  <= '0;
            res_fault <= FLT_WALK;
            st        <= ST_FIN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12: one read in flight, held request, single-cycle done
  a_r12_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  a_r12_hold_stalled_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R2: descriptor reads are 8-byte aligned
  a_r2_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
  // R10: bypass or disable never reads memory
  a_r10_bypass_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (cfg_bypass || cfg_disable)) |=> (!mem_req_valid && done));
  // R9: out-of-range input never reads memory
  a_r9_range_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_bypass && !cfg_disable && va_over) |=>
      (!mem_req_valid && res_fault == FLT_WALK));
endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cfg_ttb = '0;
  logic [5:0]  cfg_tsz = '0;
  logic [1:0]  cfg_gran = '0;
  logic        cfg_bypass = 1'b0;
  logic        cfg_disable = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        done;
  logic [47:0] res_addr;
  logic [47:0] res_mask;
  logic [7:0]  res_fault;

  ptw_walker #(.ADDR_W(48)) dut_i (.*);

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] mem [logic [47:0]];
  logic        err_en = 1'b0;
  logic [47:0] err_addr = '0;
  int          rd_cnt = 0;
  logic [47:0] first_rd = '0;
  logic [63:0] r_addr, r_mask, r_fault;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Memory model: refuses two request cycles out of three, answers one cycle later
  initial begin
    int stall = 0;
    logic pend = 1'b0;
    logic [47:0] pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(pa) ? mem[pa] : 64'd0;
        mem_rsp_err   = err_en && (pa == err_addr);
        mem_req_ready = 1'b0;
        pend = 1'b0;
      end else begin
        stall++;
        mem_req_ready = (stall % 3) == 0;
        if (mem_req_valid && mem_req_ready && rst_n) begin
          pend = 1'b1;
          pa   = mem_req_addr;
          if (rd_cnt == 0) first_rd = pa;
          rd_cnt++;
        end
      end
    end
  end

  task automatic run(input logic [63:0] va, input logic [63:0] ttb, input logic [5:0] tsz,
                     input logic [1:0] gr, input logic byp, input logic dis);
    logic got;
    @(negedge clk);
    cfg_ttb = ttb; cfg_tsz = tsz; cfg_gran = gr; cfg_bypass = byp; cfg_disable = dis;
    req_va = va; req_valid = 1'b1; rd_cnt = 0; first_rd = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", {63'd0, req_ready}, 64'd0);
    got = 1'b0;
    for (int i = 0; i < 400 && !got; i++) begin
      if (done) begin
        got = 1'b1; r_addr = res_addr; r_mask = res_mask; r_fault = res_fault;
      end else @(negedge clk);
    end
    chk("R12 done seen", {63'd0, got}, 64'd1);
    @(negedge clk);
    chk("R12 done one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_page_4k;
    mem.delete();
    mem[48'h1800] = 64'h2003;
    mem[48'h2488] = 64'h3003;
    mem[48'h3A28] = 64'h0060_0000_ABCD_E7C3;
    run(64'h40_1234_5ABC, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    chk("R2 first read level 1", first_rd, 64'h1800);
    chk("R3 three reads", rd_cnt, 3);
    chk("R4 page addr", r_addr, 64'hABCD_EABC);
    chk("R4 page mask", r_mask, 64'hFFF);
    chk("R4 fault none", r_fault, 64'h0);
  endtask

  task automatic t_blocks_4k;
    mem.delete();
    mem[48'h1800] = 64'h2003;
    mem[48'h2488] = 64'h4060_0001;
    run(64'h40_1234_5ABC, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    chk("R5 2MiB block addr", r_addr, 64'h4074_5ABC);
    chk("R5 2MiB block reads", rd_cnt, 2);
    chk("R5 block mask", r_mask, 64'hFFF);
    mem.delete();
    mem[48'h1800] = 64'h80_0000_0001;
    run(64'h40_1234_5ABC, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    chk("R5 1GiB block addr", r_addr, 64'h80_1234_5ABC);
    chk("R5 1GiB block fault", r_fault, 64'h0);
  endtask

  task automatic t_gran_16k;
    mem.delete();
    mem[48'h6488] = 64'h7E00_0001;
    run(64'h9_2345_6789, 64'hFFFF_0000_0000_4000, 6'd28, 2'd1, 1'b0, 1'b0);
    chk("R2 16K start level 2 read", first_rd, 64'h6488);
    chk("R5 32MiB block addr", r_addr, 64'h7F45_6789);
    chk("R5 16K mask", r_mask, 64'h3FFF);
    mem.delete();
    mem[48'h6488] = 64'hF003;
    mem[48'hE8A8] = 64'h1_2345_F003;
    run(64'h9_2345_6789, 64'hFFFF_0000_0000_4000, 6'd28, 2'd1, 1'b0, 1'b0);
    chk("R3 16K table low bits cleared", r_addr, 64'h1_2345_E789);
    chk("R4 16K page reads", rd_cnt, 2);
  endtask

  task automatic t_gran_64k;
    mem.delete();
    mem[48'h1AAF0] = 64'h40_0000_0001;
    run(64'h2AB_CDEF_1234, 64'h10000, 6'd22, 2'd2, 1'b0, 1'b0);
    chk("R2 64K first read", first_rd, 64'h1AAF0);
    chk("R5 512MiB block addr", r_addr, 64'h40_0DEF_1234);
    chk("R5 64K mask", r_mask, 64'hFFFF);
  endtask

  task automatic t_bad_desc;
    mem.delete();
    mem[48'h1800] = 64'h2003;
    mem[48'h2488] = 64'h3003;
    mem[48'h3A28] = 64'hABCD_E001;
    run(64'h40_1234_5ABC, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    chk("R6 reserved level3 fault", r_fault, 64'h1);
    chk("R6 reserved level3 reads", rd_cnt, 3);
    mem[48'h2488] = 64'h3002;
    run(64'h40_1234_5ABC, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    chk("R6 invalid fault", r_fault, 64'h1);
    chk("R6 invalid reads", rd_cnt, 2);
  endtask

  task automatic t_illegal_block;
    mem.delete();
    mem[48'h1800] = 64'h1;
    run(64'h8000_0000_1000, 64'h1000, 6'd16, 2'd0, 1'b0, 1'b0);
    chk("R2 level 0 read addr", first_rd, 64'h1800);
    chk("R7 level0 block fault", r_fault, 64'h1);
    mem.delete();
    mem[48'h4000] = 64'h40_0000_0001;
    run(64'h1000, 64'h4000, 6'd20, 2'd1, 1'b0, 1'b0);
    chk("R7 16K level1 block fault", r_fault, 64'h1);
    chk("R7 16K level1 reads", rd_cnt, 1);
  endtask

  task automatic t_mem_err;
    mem.delete();
    mem[48'h1800] = 64'h2003;
    err_en = 1'b1; err_addr = 48'h1800;
    run(64'h40_1234_5ABC, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    err_en = 1'b0;
    chk("R8 read error fault", r_fault, 64'h1);
    chk("R8 read error reads", rd_cnt, 1);
  endtask

  task automatic t_range;
    mem.delete();
    run(64'h80_0000_0000, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    chk("R9 over limit fault", r_fault, 64'h1);
    chk("R9 over limit no read", rd_cnt, 0);
    run(64'h7F_FFFF_FFFF, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b0);
    chk("R9 at limit walks", rd_cnt, 1);
    chk("R9 at limit read addr", first_rd, 64'h1FF8);
  endtask

  task automatic t_bypass;
    run(64'h1234_5678_9ABC_DEF0, 64'h1000, 6'd25, 2'd0, 1'b1, 1'b0);
    chk("R10 bypass addr", r_addr, 64'h5678_9ABC_DEF0);
    chk("R10 bypass mask", r_mask, 64'h0);
    chk("R10 bypass fault", r_fault, 64'h0);
    chk("R10 bypass no read", rd_cnt, 0);
    run(64'h1234_5678_9ABC_DEF0, 64'h1000, 6'd25, 2'd0, 1'b0, 1'b1);
    chk("R10 disable fault", r_fault, 64'h0);
    chk("R10 disable no read", rd_cnt, 0);
  endtask

  task automatic t_bad_cfg;
    run(64'h1000, 64'h1000, 6'd25, 2'd3, 1'b0, 1'b0);
    chk("R11 granule code 3 fault", r_fault, 64'h1);
    chk("R11 granule code 3 no read", rd_cnt, 0);
    run(64'h10, 64'h1000, 6'd55, 2'd0, 1'b0, 1'b0);
    chk("R11 tiny range fault", r_fault, 64'h1);
    chk("R11 tiny range no read", rd_cnt, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_4k();
    t_blocks_4k();
    t_gran_16k();
    t_gran_64k();
    t_bad_desc();
    t_illegal_block();
    t_mem_err();
    t_range();
    t_bypass();
    t_bad_cfg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule